// File: doc/BRIEF.md
# Floating-Point Arithmetic Trap Decision Unit

This block sits at the end of a floating-point pipeline. For each operation that completes, it decides which arithmetic traps to raise. The inputs are a class code for each of the two operands, a divide flag, and the overflow flag for the rounded result. It also takes the instruction's software-completion qualifier and five control-register bits: flush-denormals, hardware-denormal-handling, invalid mask, divide-by-zero mask and overflow mask. The outputs are three trap requests and a flag that marks the result-register write as holding an undefined value.

The mask bits apply only to instructions that carry the software-completion qualifier. Without the qualifier, every trapping condition is raised. With the qualifier, some cases skip the trap and leave the default result to other logic:
- a denormal operand when denormals are flushed, or when the hardware handles denormals directly;
- a quiet NaN or an infinity operand;
- a masked divide-by-zero, overflow or genuine invalid operation.

Three parameters say which control features exist. They are support for flushing denormals, support for hardware denormal handling, and support for a divide-by-zero mask. When the divide-by-zero mask is absent, 0/0 is reported as a divide-by-zero trap rather than an invalid trap.

Top module: `fptrap_unit`

## Requirements
- R1: Operand class codes are 0 zero, 1 denormal, 2 normal, 3 infinity, 4 quiet NaN, 5 signaling NaN; a signaling NaN in either operand always raises the invalid trap, whatever the qualifier and mask bits.
- R2: A divide of 0/0 or infinity/infinity raises the invalid trap unless the qualifier and the invalid mask are both set (when the divide-by-zero mask is supported).
- R3: A denormal operand in an otherwise valid operation raises the invalid trap, unless the qualifier is set and flushing is supported and enabled.
- R4: With the qualifier set, flush clear and hardware-denormal enabled (and supported), a denormal operand raises no trap.
- R5: A quiet NaN or infinity operand in a valid operation raises the invalid trap without the qualifier, and raises none with it, regardless of the invalid mask.
- R6: A divide with zero divisor and a normal or denormal dividend raises the divide-by-zero trap, unless the qualifier and divide-by-zero mask (when supported) are both set.
- R7: The overflow flag raises the overflow trap unless the qualifier and overflow mask are both set.
- R8: Priority is invalid over divide-by-zero over overflow; at most one trap is raised per operation.
- R9: The unpredictable-result flag is high exactly when a trap is raised.
- R10: Outputs are registered one cycle after a valid strobe, are zero the cycle after the strobe is low, and are zero in reset.
- R11: Without divide-by-zero mask support, 0/0 raises the divide-by-zero trap instead of invalid, and the divide-by-zero mask bit has no effect.
- R12: Without the qualifier, no mask, flush or hardware-denormal bit suppresses any trap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Operation completes this cycle |
| opAClass | input | 3 | Class code of the first operand (dividend) |
| opBClass | input | 3 | Class code of the second operand (divisor) |
| isDivide | input | 1 | Operation is a divide |
| roundOvf | input | 1 | Rounded result exceeds the largest finite value |
| swComplete | input | 1 | Software-completion qualifier present |
| ctlFlushDen | input | 1 | Treat denormal operands as zero |
| ctlDenHw | input | 1 | Hardware handles denormal operands |
| ctlInvMask | input | 1 | Mask invalid trap |
| ctlDivZeroMask | input | 1 | Mask divide-by-zero trap |
| ctlOvfMask | input | 1 | Mask overflow trap |
| trapInvalid | output | 1 | Invalid-operation trap request |
| trapDivZero | output | 1 | Divide-by-zero trap request |
| trapOverflow | output | 1 | Overflow trap request |
| resultUnpredictable | output | 1 | Result write holds an undefined value |

## Verification
The bench builds two copies of the block from the same inputs. The first uses the defaults, with every control feature supported. It covers the full suppression matrix, including flush taking precedence over hardware-denormal handling. The second has flushing and the divide-by-zero mask unsupported. That copy makes the 0/0 re-routing to divide-by-zero reachable, along with an ignored divide-by-zero mask and a flush bit that has no effect.

// File: rtl/fptrap_pkg.sv
package fptrap_pkg;
  localparam int CLS_W = 3;

  localparam logic [CLS_W-1:0] CLS_ZERO = 3'd0;
  localparam logic [CLS_W-1:0] CLS_DEN  = 3'd1;
  localparam logic [CLS_W-1:0] CLS_NORM = 3'd2;
  localparam logic [CLS_W-1:0] CLS_INF  = 3'd3;
  localparam logic [CLS_W-1:0] CLS_QNAN = 3'd4;
  localparam logic [CLS_W-1:0] CLS_SNAN = 3'd5;

  // suppression strobes from control to datapath
  typedef struct packed {
    logic hushInvalid;
    logic hushDenorm;
    logic hushSpecial;
    logic hushDivZero;
    logic hushOvf;
  } hushStrobesT;
endpackage

// File: rtl/fptrap_ctrl.sv
module fptrap_ctrl
  import fptrap_pkg::*;
#(
  parameter bit FLUSH_DEN_EN = 1'b1,
  parameter bit DEN_HW_EN    = 1'b1,
  parameter bit DZ_MASK_EN   = 1'b1
) (
  input  logic        swComplete,
  input  logic        ctlFlushDen,
  input  logic        ctlDenHw,
  input  logic        ctlInvMask,
  input  logic        ctlDivZeroMask,
  input  logic        ctlOvfMask,
  output hushStrobesT hush
);
  logic flushOk;
  logic hwDenOk;

  always_comb begin
    flushOk = FLUSH_DEN_EN && ctlFlushDen;
    hwDenOk = DEN_HW_EN && ctlDenHw && !ctlFlushDen;
    hush.hushInvalid = swComplete && ctlInvMask;
    hush.hushDenorm  = swComplete && (flushOk || hwDenOk);
    hush.hushSpecial = swComplete;
    hush.hushDivZero = swComplete && DZ_MASK_EN && ctlDivZeroMask;
    hush.hushOvf     = swComplete && ctlOvfMask;
  end
endmodule

// File: rtl/fptrap_dp.sv
module fptrap_dp
  import fptrap_pkg::*;
#(
  parameter bit DZ_MASK_EN = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [CLS_W-1:0] opAClass,
  input  logic [CLS_W-1:0] opBClass,
  input  logic             isDivide,
  input  logic             roundOvf,
  input  logic             swComplete,
  input  hushStrobesT      hush,
  output logic             trapInvalid,
  output logic             trapDivZero,
  output logic             trapOverflow,
  output logic             resultUnpredictable
);
  localparam bit ZZ_AS_DZ = !DZ_MASK_EN;

  logic anySnan, anyDen, anySpecial, zeroZero, infInf;
  logic ieeeInv, validOp, dzCond;
  logic nxtInv, nxtDz, nxtOvf;

  always_comb begin
    anySnan    = (opAClass == CLS_SNAN) || (opBClass == CLS_SNAN);
    anyDen     = (opAClass == CLS_DEN) || (opBClass == CLS_DEN);
    anySpecial = (opAClass == CLS_QNAN) || (opBClass == CLS_QNAN) ||
                 (opAClass == CLS_INF)  || (opBClass == CLS_INF);
    zeroZero   = (opAClass == CLS_ZERO) && (opBClass == CLS_ZERO);
    infInf     = (opAClass == CLS_INF) && (opBClass == CLS_INF);
    ieeeInv    = isDivide && ((zeroZero && !ZZ_AS_DZ) || infInf);
    validOp    = !anySnan && !ieeeInv;

    nxtInv = anySnan
          || (ieeeInv && !hush.hushInvalid)
          || (validOp && anyDen && !hush.hushDenorm)
          || (validOp && anySpecial && !hush.hushSpecial);

    dzCond = isDivide && (opBClass == CLS_ZERO) &&
             ((opAClass == CLS_NORM) || (opAClass == CLS_DEN) ||
              (ZZ_AS_DZ && opAClass == CLS_ZERO));
    nxtDz  = dzCond && !nxtInv && !hush.hushDivZero;
    nxtOvf = roundOvf && !nxtInv && !nxtDz && !hush.hushOvf;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      trapInvalid         <= 1'b0;
      trapDivZero         <= 1'b0;
      trapOverflow        <= 1'b0;
      resultUnpredictable <= 1'b0;
    end else begin
      trapInvalid         <= inValid && nxtInv;
      trapDivZero         <= inValid && nxtDz;
      trapOverflow        <= inValid && nxtOvf;
      resultUnpredictable <= inValid && (nxtInv || nxtDz || nxtOvf);
    end
  end

  assert_snan_invalid_R1: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && (opAClass == CLS_SNAN || opBClass == CLS_SNAN)) |=> trapInvalid);

  assert_one_trap_R8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({trapInvalid, trapDivZero, trapOverflow}));

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !(trapInvalid || trapDivZero || trapOverflow || resultUnpredictable));

  assert_no_hush_R12: assert property (@(posedge clk) disable iff (!rstN)
    !swComplete |-> (hush == '0));

  assert_div_zero_R6: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !swComplete && isDivide && opAClass == CLS_NORM &&
     opBClass == CLS_ZERO) |=> trapDivZero);
endmodule

// File: rtl/fptrap_unit.sv
module fptrap_unit
  import fptrap_pkg::*;
#(
  parameter bit FLUSH_DEN_EN = 1'b1,
  parameter bit DEN_HW_EN    = 1'b1,
  parameter bit DZ_MASK_EN   = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [CLS_W-1:0] opAClass,
  input  logic [CLS_W-1:0] opBClass,
  input  logic             isDivide,
  input  logic             roundOvf,
  input  logic             swComplete,
  input  logic             ctlFlushDen,
  input  logic             ctlDenHw,
  input  logic             ctlInvMask,
  input  logic             ctlDivZeroMask,
  input  logic             ctlOvfMask,
  output logic             trapInvalid,
  output logic             trapDivZero,
  output logic             trapOverflow,
  output logic             resultUnpredictable
);
  hushStrobesT hush;

  fptrap_ctrl #(
    .FLUSH_DEN_EN(FLUSH_DEN_EN),
    .DEN_HW_EN   (DEN_HW_EN),
    .DZ_MASK_EN  (DZ_MASK_EN)
  ) u_ctrl (
    .swComplete    (swComplete),
    .ctlFlushDen   (ctlFlushDen),
    .ctlDenHw      (ctlDenHw),
    .ctlInvMask    (ctlInvMask),
    .ctlDivZeroMask(ctlDivZeroMask),
    .ctlOvfMask    (ctlOvfMask),
    .hush          (hush)
  );

  fptrap_dp #(
    .DZ_MASK_EN(DZ_MASK_EN)
  ) u_dp (
    .clk                (clk),
    .rstN               (rstN),
    .inValid            (inValid),
    .opAClass           (opAClass),
    .opBClass           (opBClass),
    .isDivide           (isDivide),
    .roundOvf           (roundOvf),
    .swComplete         (swComplete),
    .hush               (hush),
    .trapInvalid        (trapInvalid),
    .trapDivZero        (trapDivZero),
    .trapOverflow       (trapOverflow),
    .resultUnpredictable(resultUnpredictable)
  );
endmodule

// File: tb/fptrap_unit_tb.sv
module fptrap_unit_tb;
  localparam logic [2:0] Z = 3'd0, D = 3'd1, N = 3'd2, I = 3'd3, Q = 3'd4, S = 3'd5;
  localparam int NVEC = 24;
  // {a, b, div ovf sw flush denHw invM dzM ovfM, expInv expDz expOvf}
  localparam logic [16:0] VEC [NVEC] = '{
    {N, N, 8'b00000000, 3'b000},  // baseline
    {S, N, 8'b00100100, 3'b100},  // R1
    {N, S, 8'b01000000, 3'b100},  // R1
    {Z, Z, 8'b10000000, 3'b100},  // R2
    {Z, Z, 8'b10100100, 3'b000},  // R2
    {I, I, 8'b10100000, 3'b100},  // R2
    {D, N, 8'b00000000, 3'b100},  // R3
    {D, N, 8'b00110000, 3'b000},  // R3
    {N, D, 8'b00101000, 3'b000},  // R4
    {N, D, 8'b00001000, 3'b100},  // R12
    {Q, N, 8'b00000000, 3'b100},  // R5
    {I, N, 8'b00100000, 3'b000},  // R5
    {Q, N, 8'b00100100, 3'b000},  // R5
    {N, Z, 8'b10000000, 3'b010},  // R6
    {N, Z, 8'b10100010, 3'b000},  // R6
    {N, Z, 8'b10000010, 3'b010},  // R12
    {N, N, 8'b01000000, 3'b001},  // R7
    {N, N, 8'b01100001, 3'b000},  // R7
    {N, N, 8'b01000001, 3'b001},  // R12
    {D, Z, 8'b11000000, 3'b100},  // R8
    {N, Z, 8'b11000000, 3'b010},  // R8
    {D, Z, 8'b10110000, 3'b010},  // R3
    {D, N, 8'b00100000, 3'b100},  // R3
    {N, D, 8'b00111000, 3'b000}   // R4
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic [2:0] opAClass = 3'd0, opBClass = 3'd0;
  logic isDivide = 1'b0, roundOvf = 1'b0, swComplete = 1'b0;
  logic ctlFlushDen = 1'b0, ctlDenHw = 1'b0, ctlInvMask = 1'b0;
  logic ctlDivZeroMask = 1'b0, ctlOvfMask = 1'b0;
  logic tInv, tDz, tOvf, tUnp;
  logic aInv, aDz, aOvf, aUnp;
  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  fptrap_unit u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opAClass(opAClass), .opBClass(opBClass),
    .isDivide(isDivide), .roundOvf(roundOvf), .swComplete(swComplete),
    .ctlFlushDen(ctlFlushDen), .ctlDenHw(ctlDenHw), .ctlInvMask(ctlInvMask),
    .ctlDivZeroMask(ctlDivZeroMask), .ctlOvfMask(ctlOvfMask),
    .trapInvalid(tInv), .trapDivZero(tDz), .trapOverflow(tOvf), .resultUnpredictable(tUnp));

  fptrap_unit #(.FLUSH_DEN_EN(1'b0), .DEN_HW_EN(1'b1), .DZ_MASK_EN(1'b0)) u_dutAlt (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opAClass(opAClass), .opBClass(opBClass),
    .isDivide(isDivide), .roundOvf(roundOvf), .swComplete(swComplete),
    .ctlFlushDen(ctlFlushDen), .ctlDenHw(ctlDenHw), .ctlInvMask(ctlInvMask),
    .ctlDivZeroMask(ctlDivZeroMask), .ctlOvfMask(ctlOvfMask),
    .trapInvalid(aInv), .trapDivZero(aDz), .trapOverflow(aOvf), .resultUnpredictable(aUnp));

  task automatic check(input string tag, input logic [3:0] got, input logic [3:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got inv/dz/ovf/unp=%b expected %b", tag, got, exp);
    end
  endtask

  task automatic drive(input logic [13:0] st, input logic v);
    @(negedge clk);
    inValid = v;
    {opAClass, opBClass, isDivide, roundOvf, swComplete, ctlFlushDen,
     ctlDenHw, ctlInvMask, ctlDivZeroMask, ctlOvfMask} = st;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    inValid = 1'b1;
    opAClass = S;
    #5 check("R10 reset holds outputs low", {tInv, tDz, tOvf, tUnp}, 4'b0000);
    @(negedge clk);
    rstN = 1'b1;
    inValid = 1'b0;

    for (int k = 0; k < NVEC; k++) begin
      logic [2:0] e;
      e = VEC[k][2:0];
      drive(VEC[k][16:3], 1'b1);
      check($sformatf("R1-table vector %0d (R9 flag)", k), {tInv, tDz, tOvf, tUnp}, {e, |e});
    end

    // R10: strobe low gives zero, sNaN present
    drive({S, S, 8'b00000000}, 1'b0);
    check("R10 strobe low", {tInv, tDz, tOvf, tUnp}, 4'b0000);
    // R10: latency exactly one edge
    @(negedge clk);
    inValid = 1'b1;
    #5 check("R10 before edge", {tInv, tDz, tOvf, tUnp}, 4'b0000);
    @(negedge clk);
    check("R10 after edge", {tInv, tDz, tOvf, tUnp}, 4'b1001);

    // R11 and R3 on the variant build
    drive({D, N, 8'b00110000}, 1'b1);
    check("R3 flush unsupported", {aInv, aDz, aOvf, aUnp}, 4'b1001);
    drive({Z, Z, 8'b10000000}, 1'b1);
    check("R11 zero/zero as divzero", {aInv, aDz, aOvf, aUnp}, 4'b0101);
    check("R2 zero/zero invalid default", {tInv, tDz, tOvf, tUnp}, 4'b1001);
    drive({Z, Z, 8'b10100110}, 1'b1);
    check("R11 mask ignored zero/zero", {aInv, aDz, aOvf, aUnp}, 4'b0101);
    check("R2 masked zero/zero default", {tInv, tDz, tOvf, tUnp}, 4'b0000);
    drive({N, Z, 8'b10100010}, 1'b1);
    check("R11 divzero mask ignored", {aInv, aDz, aOvf, aUnp}, 4'b0101);
    drive({N, D, 8'b00101000}, 1'b1);
    check("R4 hw denormal variant", {aInv, aDz, aOvf, aUnp}, 4'b0000);

    @(negedge clk);
    inValid = 1'b0;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule